// File: doc/BRIEF.md
# Programmable Even Clock Divider

This block takes a reference clock and produces a slower clock whose frequency is the reference divided by an even ratio between 2 and 30. The ratio is chosen with a small divide code: the output period is always twice the code value in reference cycles. A code of zero turns the output off. The output is driven from a register, so it never glitches, and its high and low phases are always equal in length.

Inside, a prescaler counter divides by the code value, from 1 to 15. Each time the counter wraps, a toggle stage flips the output, which gives the factor of two and the exact 50:50 shape. The code is sampled only when the prescaler wraps, or at any cycle while the output is off. A new setting therefore never cuts a half-period short. After reset the block runs at a ratio of 8.

Top module: `even_clk_divider`

## Requirements
- R1: For a divide code N from 1 to 15, the output period is 2*N reference cycles.
- R2: For every nonzero code, each high phase and each low phase of the output lasts exactly N reference cycles.
- R3: While the active code is 0, the output stays low and the prescaler count stays at 0.
- R4: A code change made during a half-period does not shorten or lengthen that half-period; it still lasts the old N cycles. Every later half-period uses the new N.
- R5: During reset and in the first cycle after it, the output is low. The active setting resets to 4 whatever the input code is, so the first low phase after reset release lasts 4 cycles, counting the cycle in which reset is released.
- R6: When the output is off and a nonzero code N is applied, the code is captured at the next clock edge with the output still low. The output then stays low for N more cycles before its first rising edge.
- R7: When the code changes to 0, the half-period in progress completes at the old length. The output then stays low with no further pulse.
- R8: The output changes level only on the cycle after a prescaler wrap, and the prescaler count stays below the active code while it is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_code | input | 4 | Divide code N: output ratio is 2*N; 0 turns the output off |
| div_clk_o | output | 1 | Divided 50:50 output clock, registered |

## Verification
The bench builds the block with its default parameters: a 4-bit code and a reset setting of 4. With these defaults every code value can be swept, and so can every pair of old and new codes, including changes into and out of zero. For each code the bench measures the high and low phase lengths and the delay to the first edge. For each pair it places the change in the middle of a high phase and checks that this phase ends at the old length while the following phases take the new one.

// File: rtl/ediv_pkg.sv
// Package: shared types and helpers for the even clock divider.
// Assumes: codes are unsigned; a code of zero means "output off".
package ediv_pkg;

    // Output phase of the divided clock.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } ediv_phase_t;

    // Returns the phase that follows a wrap, given whether the next code is zero.
    function automatic ediv_phase_t ediv_next_phase(input ediv_phase_t cur, input logic next_off);
        if (next_off) begin
            return PH_LOW;
        end
        return (cur == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/ediv_ratio_reg.sv
// Module: holds the active divide code used by the prescaler.
// What it does: samples the input code only at a prescaler wrap, or at any
// cycle while the active code is zero (output off), so a running half-period
// is never cut short.
// Assumes: wrap_i is a single-cycle pulse from the prescaler.
module ediv_ratio_reg #(
    parameter int CODE_W    = 4,
    parameter int RESET_VAL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              wrap_i,
    output logic [CODE_W-1:0] active_o,
    output logic              off_o
);

    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_VAL);

    logic [CODE_W-1:0] active_q;

    // Load the new code at a wrap or while stopped; reset to the default ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= RST_CODE;
        end else if (wrap_i || (active_q == '0)) begin
            active_q <= code_i;
        end
    end

    // Flag the stopped state for downstream stages.
    always_comb begin
        off_o = (active_q == '0);
    end

    assign active_o = active_q;

    // The active code moves only at a wrap or while stopped.
    AST_CODE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> ($past(wrap_i) || ($past(active_q) == '0))); // R4

endmodule

// File: rtl/ediv_prescaler.sv
// Module: divide-by-N prescaler counter, N from 1 to 2**CODE_W-1.
// What it does: counts 0..N-1 and pulses wrap_o on the last count; held at
// zero while the active code is zero.
// Assumes: active_i changes only in the cycle after a wrap or while stopped.
module ediv_prescaler #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] active_i,
    output logic [CODE_W-1:0] count_o,
    output logic              wrap_o
);

    logic [CODE_W-1:0] count_q;
    logic [CODE_W-1:0] last_cnt;
    logic              stopped;

    // Decode the terminal count for the current ratio.
    always_comb begin
        stopped  = (active_i == '0);
        last_cnt = active_i - 1'b1;
        wrap_o   = !stopped && (count_q == last_cnt);
    end

    // Advance the count, restarting at a wrap and parking at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (stopped || wrap_o) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // The count never reaches the active ratio.
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i != '0) |-> (count_q < active_i)); // R8

    // A stopped prescaler stays parked at zero.
    AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active_i) == '0) |-> (count_q == '0)); // R3

endmodule

// File: rtl/ediv_toggle.sv
// Module: divide-by-2 toggle stage producing the 50:50 output.
// What it does: flips the output at every prescaler wrap; forces it low at a
// wrap that enters the stopped state.
// Assumes: wrap_i never pulses while the prescaler is stopped.
module ediv_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic next_off_i,
    output logic clk_o
);

    import ediv_pkg::*;

    ediv_phase_t phase_q;

    // Update the phase only at a wrap; reset to low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
        end else if (wrap_i) begin
            phase_q <= ediv_next_phase(phase_q, next_off_i);
        end
    end

    assign clk_o = (phase_q == PH_HIGH);

    // Output edges only follow a wrap.
    AST_EDGE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_o) |-> $past(wrap_i)); // R8

endmodule

// File: rtl/even_clk_divider.sv
// Module: top of the programmable even clock divider.
// What it does: prescaler (divide by code) followed by a toggle stage, for an
// overall even ratio of 2*code with 50:50 duty; code 0 stops the output low.
// Assumes: one clock domain, synchronous active-low reset, code may change
// at any cycle.
module even_clk_divider #(
    parameter int CODE_W    = 4,
    parameter int RESET_VAL = 4
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              div_clk_o
);

    logic [CODE_W-1:0] active_code;
    logic [CODE_W-1:0] pre_count;
    logic              pre_wrap;
    logic              is_off;
    logic              next_off;

    // A wrap that loads a zero code must leave the output low.
    always_comb begin
        next_off = (div_code == '0);
    end

    ediv_ratio_reg #(
        .CODE_W    (CODE_W),
        .RESET_VAL (RESET_VAL)
    ) ratio_i (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .code_i   (div_code),
        .wrap_i   (pre_wrap),
        .active_o (active_code),
        .off_o    (is_off)
    );

    ediv_prescaler #(
        .CODE_W (CODE_W)
    ) pre_i (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .active_i (active_code),
        .count_o  (pre_count),
        .wrap_o   (pre_wrap)
    );

    ediv_toggle tog_i (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .wrap_i     (pre_wrap),
        .next_off_i (next_off),
        .clk_o      (div_clk_o)
    );

    // Stopped state: output low and counter parked.
    AST_OFF_IS_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        is_off |-> (!div_clk_o && (pre_count == '0))); // R3

    // Leaving the stopped state starts from a low output.
    AST_RESTART_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(is_off) && !is_off) |-> !div_clk_o); // R6

    // A high phase ends only at a wrap, never early when the code goes to zero.
    AST_NO_RUNT_ON_STOP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(div_clk_o) |-> ($past(pre_count) == $past(active_code) - 1'b1)); // R7

endmodule

// File: tb/even_clk_divider_tb_top.sv
module even_clk_divider_tb_top;

    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [3:0] div_code = 4'd9;
    logic       div_clk_o;

    int checks = 0;
    int errors = 0;

    always #2 ref_clk = ~ref_clk;

    even_clk_divider dut_i (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .div_code  (div_code),
        .div_clk_o (div_clk_o)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step();
        @(negedge ref_clk);
    endtask

    // Length of the run that starts at the current sample.
    task automatic run_len(output int n);
        logic v;
        v = div_clk_o;
        n = 0;
        while (div_clk_o == v && n < 100) begin
            n++;
            step();
        end
    endtask

    // Count low samples over a window; all must be low.
    task automatic hold_low(input string req, input int cycles);
        int highs;
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            if (div_clk_o) highs++;
            step();
        end
        check(highs == 0, req, highs, 0);
    endtask

    // Stop the output, then start code n; ends on the first high sample.
    task automatic start_from_off(input int n, input bit verify);
        int lows;
        div_code = 4'd0;
        for (int i = 0; i < 40; i++) step();
        if (verify) hold_low("R3", 8);
        div_code = 4'(n);
        step();
        lows = 0;
        while (!div_clk_o && lows < 100) begin
            lows++;
            step();
        end
        if (verify) check(lows == n, "R6", lows, n);
    endtask

    initial begin
        int n, a, b;
        // Reset phase: output low regardless of code.
        repeat (3) step();
        check(div_clk_o == 1'b0, "R5", div_clk_o, 0);
        rst_n = 1'b1;
        check(div_clk_o == 1'b0, "R5", div_clk_o, 0);
        run_len(n);
        check(n == 4, "R5", n, 4);
        run_len(n);
        check(n == 9, "R4", n, 9);

        // Sweep every nonzero code: delay, phases, period.
        for (int c = 1; c < 16; c++) begin
            start_from_off(c, 1'b1);
            run_len(a);
            check(a == c, "R2", a, c);
            run_len(b);
            check(b == c, "R2", b, c);
            check(a + b == 2 * c, "R1", a + b, 2 * c);
        end

        // Every old/new pair, change placed mid high phase.
        for (int o = 1; o < 16; o++) begin
            for (int w = 0; w < 16; w++) begin
                start_from_off(o, 1'b0);
                n = 0;
                for (int k = 0; k < o / 2; k++) begin
                    n++;
                    step();
                end
                div_code = 4'(w);
                while (div_clk_o && n < 100) begin
                    n++;
                    step();
                end
                if (w == 0) begin
                    check(n == o, "R7", n, o);
                    hold_low("R7", 40);
                end else begin
                    check(n == o, "R4", n, o);
                    run_len(a);
                    check(a == w, "R4", a, w);
                    run_len(b);
                    check(b == w, "R4", b, w);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule